// File: doc/BRIEF.md
# Prioritised Address Window Translator

This block sits between a local bus and a PCI host port. It converts a local-bus address into a PCI bus address using three programmable windows, each made of a base word (the local-side range) and a map word (the PCI-side target). Two of the windows reach PCI memory space and have a power-of-two size. The third reaches PCI I/O space with a fixed 16 MB granularity. Windows may overlap. The lowest-numbered enabled window that covers an address always wins, so software can enlarge one window to hide another while it reprograms it.

Each request presents one local address. One cycle later the block returns one of two results. On a hit it gives the translated PCI address, the PCI cycle type, and the index of the window that won. If no enabled window covers the address it raises a miss flag instead, and no cycle is produced.

The window words are written through a small register port. A system word carries a lock flag. While the lock is set, every write to the window words is dropped. The lock is cleared only by writing a fixed key.

Top module: `awin_xlate`

## Requirements
- R1: After reset, `xl_valid`, `xl_miss` and `locked` are 0, and every window is disabled, so any request misses.
- R2: A memory window (index 0 or 1) is enabled by bit 0 of its base word. Base bits 31:20 give the local address and bits 7:4 give a size code n. The window covers 1 MB << n bytes, aligned to its own size. Base bits below the size boundary are ignored. The window covers an address exactly when that address lies inside this aligned range.
- R3: On a memory-window hit the PCI address has two parts. Above the window size it takes map bits 15:4, placed at address bits 31:20. Inside the window it keeps the local offset.
- R4: A memory-window hit reports map bits 3:1 as the cycle type (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple). An I/O-window hit always reports 001.
- R5: On a memory-window hit, map bit 0 = 0 drives PCI address bits 1:0 as 00. Map bit 0 = 1 passes local address bits 1:0 through.
- R6: When several enabled windows cover an address, the lowest index wins. `xl_win` reports that index.
- R7: The I/O window (index 2) is enabled by base bit 0. It covers the 16 MB block whose address bits 31:24 equal base bits 15:8. It replaces those bits with map bits 15:8 and keeps local bits 23:0.
- R8: A request that no enabled window covers gives `xl_miss` = 1 and `xl_valid` = 0. A size code above 11 never matches.
- R9: Register selector codes are: base0 = 0, map0 = 1, base1 = 2, map1 = 3, I/O base = 4, I/O map = 5, system = 6. A system write of 0xA05F in bits 15:0 clears the lock. Any other system write with bit 14 set sets the lock. While the lock is set, writes to codes 0 to 5 are ignored.
- R10: The result appears on the clock edge that samples `req_valid`. A cycle without a request leaves both `xl_valid` and `xl_miss` low. Translation uses the window words as they stood before any write on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Register write data (16-bit words use bits 15:0) |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Local-bus address |
| locked | output | 1 | Lock flag state |
| xl_valid | output | 1 | Registered hit result |
| xl_miss | output | 1 | Registered miss result |
| xl_addr | output | 32 | Translated PCI address |
| xl_type | output | 3 | PCI cycle type |
| xl_win | output | 2 | Index of the winning window |

## Verification
The assertions assume two things about the inputs. First, `cfg_sel` codes above 6 carry no meaning. Second, a register write and a request on the same edge resolve with the pre-write words. The bench model follows the same rule, so overlapping writes and requests are legal stimulus. Stimulus is driven on the falling edge, so every input is stable at the sampling edge. Random register writes use only codes 0 to 6, and they include lock, unlock and size codes above 11. This lets the model cover locked drops and dead windows alongside the directed overlap cases.

// File: rtl/awin_pkg.sv
package awin_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    CYC_IACK    = 3'b000,
    CYC_IO      = 3'b001,
    CYC_MEM     = 3'b011,
    CYC_CFG     = 3'b101,
    CYC_MEMMULT = 3'b110
  } cyc_e;

  localparam logic [WORD_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam int                LOCK_BIT   = 14;
endpackage

// File: rtl/awin_regs.sv
module awin_regs
  import awin_pkg::*;
#(
  parameter int MEM_WINS = 2,
  parameter int SEL_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [SEL_W-1:0]                   cfg_sel,
  input  logic [ADDR_W-1:0]                  cfg_wdata,
  output logic [MEM_WINS-1:0][ADDR_W-1:0]    mem_base,
  output logic [MEM_WINS-1:0][WORD_W-1:0]    mem_map,
  output logic [WORD_W-1:0]                  io_base,
  output logic [WORD_W-1:0]                  io_map,
  output logic                               lock
);
  localparam int IO_BASE_SEL = 2 * MEM_WINS;
  localparam int IO_MAP_SEL  = IO_BASE_SEL + 1;
  localparam int SYS_SEL     = IO_BASE_SEL + 2;

  logic [MEM_WINS-1:0][ADDR_W-1:0] mem_base_q, mem_base_d;
  logic [MEM_WINS-1:0][WORD_W-1:0] mem_map_q, mem_map_d;
  logic [WORD_W-1:0]               io_base_q, io_base_d, io_map_q, io_map_d;
  logic                            lock_q, lock_d;
  logic                            win_wr_ok, sys_wr;

  always_comb begin
    mem_base_d = mem_base_q;
    mem_map_d  = mem_map_q;
    io_base_d  = io_base_q;
    io_map_d   = io_map_q;
    lock_d     = lock_q;
    win_wr_ok  = cfg_we && !lock_q;
    sys_wr     = cfg_we && (cfg_sel == SEL_W'(SYS_SEL));
    for (int i = 0; i < MEM_WINS; i++) begin
      if (win_wr_ok && cfg_sel == SEL_W'(2 * i))
        mem_base_d[i] = cfg_wdata;
      if (win_wr_ok && cfg_sel == SEL_W'(2 * i + 1))
        mem_map_d[i] = cfg_wdata[WORD_W-1:0];
    end
    if (win_wr_ok && cfg_sel == SEL_W'(IO_BASE_SEL))
      io_base_d = cfg_wdata[WORD_W-1:0];
    if (win_wr_ok && cfg_sel == SEL_W'(IO_MAP_SEL))
      io_map_d = cfg_wdata[WORD_W-1:0];
    if (sys_wr) begin
      if (cfg_wdata[WORD_W-1:0] == UNLOCK_KEY)
        lock_d = 1'b0;
      else if (cfg_wdata[LOCK_BIT])
        lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_base_q <= '0;
      mem_map_q  <= '0;
      io_base_q  <= '0;
      io_map_q   <= '0;
      lock_q     <= 1'b0;
    end else if (cfg_we) begin
      mem_base_q <= mem_base_d;
      mem_map_q  <= mem_map_d;
      io_base_q  <= io_base_d;
      io_map_q   <= io_map_d;
      lock_q     <= lock_d;
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^cfg_wdata[ADDR_W-1:WORD_W];

  assign mem_base = mem_base_q;
  assign mem_map  = mem_map_q;
  assign io_base  = io_base_q;
  assign io_map   = io_map_q;
  assign lock     = lock_q;

  // R9: window words hold while locked
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && lock_q && cfg_sel != SEL_W'(SYS_SEL)) |=>
      ($stable(mem_base_q) && $stable(mem_map_q) && $stable(io_base_q) && $stable(io_map_q)));

  // R9: key clears the lock
  a_r9_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(SYS_SEL) && cfg_wdata[WORD_W-1:0] == UNLOCK_KEY) |=> !lock_q);

  // R9: bit 14 sets the lock
  a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(SYS_SEL) && cfg_wdata[WORD_W-1:0] != UNLOCK_KEY
     && cfg_wdata[LOCK_BIT]) |=> lock_q);
endmodule

// File: rtl/awin_memwin.sv
module awin_memwin
  import awin_pkg::*;
#(
  parameter int GRAN_LOG = 20,
  parameter int MAX_SZC  = 11
) (
  input  logic [ADDR_W-1:0] base_w,
  input  logic [WORD_W-1:0] map_w,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr,
  output logic [2:0]        ctype
);
  localparam int FLD_W = ADDR_W - GRAN_LOG;

  logic [3:0]        szc;
  logic              size_ok, lowen;
  logic [5:0]        shamt;
  logic [ADDR_W-1:0] mask, lb_base, pci_base, raw;

  always_comb begin
    szc      = base_w[7:4];
    lowen    = map_w[0];
    size_ok  = (szc <= 4'(MAX_SZC));
    shamt    = 6'(GRAN_LOG) + {2'b00, szc};
    mask     = (ADDR_W'(1) << shamt) - ADDR_W'(1);
    lb_base  = {base_w[ADDR_W-1 -: FLD_W], {GRAN_LOG{1'b0}}};
    pci_base = {map_w[WORD_W-1 -: FLD_W], {GRAN_LOG{1'b0}}};
    hit      = base_w[0] && size_ok && (((addr ^ lb_base) & ~mask) == '0);
    raw      = (pci_base & ~mask) | (addr & mask);
    xaddr    = lowen ? raw : {raw[ADDR_W-1:2], 2'b00};
    ctype    = map_w[3:1];
  end

  logic unused_fields;
  assign unused_fields = ^{base_w[GRAN_LOG-1:8], base_w[3:1]};
endmodule

// File: rtl/awin_iowin.sv
module awin_iowin
  import awin_pkg::*;
#(
  parameter int IO_GRAN_LOG = 24
) (
  input  logic [WORD_W-1:0] base_w,
  input  logic [WORD_W-1:0] map_w,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  localparam int FLD_W = ADDR_W - IO_GRAN_LOG;

  always_comb begin
    hit   = base_w[0] && (addr[ADDR_W-1 -: FLD_W] == base_w[WORD_W-1 -: FLD_W]);
    xaddr = {map_w[WORD_W-1 -: FLD_W], addr[IO_GRAN_LOG-1:0]};
  end

  logic unused_fields;
  assign unused_fields = ^{base_w[WORD_W-FLD_W-1:1], map_w[WORD_W-FLD_W-1:0]};
endmodule

// File: rtl/awin_pick.sv
module awin_pick
  import awin_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int IDX_W = 2
) (
  input  logic [NWIN-1:0]             hit,
  input  logic [NWIN-1:0][ADDR_W-1:0] xaddr,
  input  logic [NWIN-1:0][2:0]        ctype,
  output logic                        any,
  output logic [IDX_W-1:0]            idx,
  output logic [ADDR_W-1:0]           sel_addr,
  output logic [2:0]                  sel_type
);
  always_comb begin
    any      = 1'b0;
    idx      = '0;
    sel_addr = '0;
    sel_type = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        sel_addr = xaddr[i];
        sel_type = ctype[i];
      end
    end
  end
endmodule

// File: rtl/awin_xlate.sv
module awin_xlate
  import awin_pkg::*;
#(
  parameter int MEM_WINS    = 2,
  parameter int GRAN_LOG    = 20,
  parameter int IO_GRAN_LOG = 24,
  parameter int MAX_SZC     = 11
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [$clog2(2*MEM_WINS+3)-1:0]       cfg_sel,
  input  logic [31:0]                           cfg_wdata,
  input  logic                                  req_valid,
  input  logic [31:0]                           req_addr,
  output logic                                  locked,
  output logic                                  xl_valid,
  output logic                                  xl_miss,
  output logic [31:0]                           xl_addr,
  output logic [2:0]                            xl_type,
  output logic [$clog2(MEM_WINS+1)-1:0]         xl_win
);
  localparam int NWIN  = MEM_WINS + 1;
  localparam int SEL_W = $clog2(2 * MEM_WINS + 3);
  localparam int IDX_W = $clog2(NWIN);

  logic [MEM_WINS-1:0][ADDR_W-1:0] mem_base;
  logic [MEM_WINS-1:0][WORD_W-1:0] mem_map;
  logic [WORD_W-1:0]               io_base, io_map;
  logic [NWIN-1:0]                 hit_vec;
  logic [NWIN-1:0][ADDR_W-1:0]     xaddr_vec;
  logic [NWIN-1:0][2:0]            ctype_vec;
  logic                            any_hit;
  logic [IDX_W-1:0]                win_idx;
  logic [ADDR_W-1:0]               pick_addr;
  logic [2:0]                      pick_type;

  awin_regs #(.MEM_WINS(MEM_WINS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_base(mem_base), .mem_map(mem_map),
    .io_base(io_base), .io_map(io_map), .lock(locked)
  );

  for (genvar g = 0; g < MEM_WINS; g++) begin : g_mem
    awin_memwin #(.GRAN_LOG(GRAN_LOG), .MAX_SZC(MAX_SZC)) u_win (
      .base_w(mem_base[g]), .map_w(mem_map[g]), .addr(req_addr),
      .hit(hit_vec[g]), .xaddr(xaddr_vec[g]), .ctype(ctype_vec[g])
    );
  end

  awin_iowin #(.IO_GRAN_LOG(IO_GRAN_LOG)) u_io (
    .base_w(io_base), .map_w(io_map), .addr(req_addr),
    .hit(hit_vec[MEM_WINS]), .xaddr(xaddr_vec[MEM_WINS])
  );
  assign ctype_vec[MEM_WINS] = CYC_IO;

  awin_pick #(.NWIN(NWIN), .IDX_W(IDX_W)) u_pick (
    .hit(hit_vec), .xaddr(xaddr_vec), .ctype(ctype_vec),
    .any(any_hit), .idx(win_idx), .sel_addr(pick_addr), .sel_type(pick_type)
  );

  logic              valid_q, valid_d, miss_q, miss_d, res_en;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        type_q;
  logic [IDX_W-1:0]  win_q;

  always_comb begin
    valid_d = req_valid && any_hit;
    miss_d  = req_valid && !any_hit;
    res_en  = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      type_q <= '0;
      win_q  <= '0;
    end else if (res_en) begin
      addr_q <= pick_addr;
      type_q <= pick_type;
      win_q  <= win_idx;
    end
  end

  assign xl_valid = valid_q;
  assign xl_miss  = miss_q;
  assign xl_addr  = addr_q;
  assign xl_type  = type_q;
  assign xl_win   = win_q;

  // R10: one result per request, one cycle later
  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (xl_valid ^ xl_miss));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!xl_valid && !xl_miss));
  // R8: hit and miss never together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_valid && xl_miss));
  // R6: window 0 always wins when it matches
  a_r6_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec[0]) |=> (xl_valid && xl_win == '0));
  // R4: the I/O window always reports an I/O cycle
  a_r4_io_type: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_win == IDX_W'(MEM_WINS)) |-> (xl_type == CYC_IO));
endmodule

// File: tb/awin_xlate_bench.sv
module awin_xlate_bench;
  logic        clk, rst_n, cfg_we, req_valid;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, req_addr;
  logic        locked, xl_valid, xl_miss;
  logic [31:0] xl_addr;
  logic [2:0]  xl_type;
  logic [1:0]  xl_win;

  awin_xlate u_awin_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .locked(locked), .xl_valid(xl_valid), .xl_miss(xl_miss),
    .xl_addr(xl_addr), .xl_type(xl_type), .xl_win(xl_win)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;
  string cur_tag = "R10";
  string exp_tag = "R10";

  bit [31:0] mb [2];
  bit [15:0] mm [2];
  bit [15:0] io_b, io_m;
  bit        m_lock;
  bit        e_valid, e_miss, e_lock;
  bit [31:0] e_addr;
  bit [2:0]  e_type;
  bit [1:0]  e_win;

  function automatic void mdl(input bit [31:0] a, output bit h, output bit [1:0] w,
                              output bit [31:0] x, output bit [2:0] t);
    h = 0; w = 0; x = 0; t = 0;
    for (int i = 0; i < 2; i++) begin
      if (!h && mb[i][0] && mb[i][7:4] <= 11) begin
        longint sz, lb, pb, av;
        sz = longint'(1) << (20 + mb[i][7:4]);
        lb = (longint'({32'b0, mb[i][31:20], 20'h0}) / sz) * sz;
        av = longint'({32'b0, a});
        if (av >= lb && av < lb + sz) begin
          pb = (longint'({32'b0, mm[i][15:4], 20'h0}) / sz) * sz;
          x = 32'(pb + (av - lb));
          if (!mm[i][0]) x[1:0] = 2'b00;
          t = mm[i][3:1];
          w = 2'(i);
          h = 1;
        end
      end
    end
    if (!h && io_b[0] && a[31:24] == io_b[15:8]) begin
      x = {io_m[15:8], 24'h0} + (a - {io_b[15:8], 24'h0});
      t = 3'b001; w = 2'd2; h = 1;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mb[0] = 0; mb[1] = 0; mm[0] = 0; mm[1] = 0; io_b = 0; io_m = 0; m_lock = 0;
      e_valid = 0; e_miss = 0; e_lock = 0;
    end else begin
      bit h; bit [1:0] w; bit [31:0] x; bit [2:0] t;
      mdl(req_addr, h, w, x, t);
      e_valid = req_valid && h;
      e_miss  = req_valid && !h;
      if (e_valid) begin e_addr = x; e_type = t; e_win = w; end
      exp_tag = cur_tag;
      if (cfg_we) begin
        if (cfg_sel == 6) begin
          if (cfg_wdata[15:0] == 16'hA05F) m_lock = 0;
          else if (cfg_wdata[14]) m_lock = 1;
        end else if (!m_lock) begin
          case (cfg_sel)
            3'd0: mb[0] = cfg_wdata;
            3'd1: mm[0] = cfg_wdata[15:0];
            3'd2: mb[1] = cfg_wdata;
            3'd3: mm[1] = cfg_wdata[15:0];
            3'd4: io_b  = cfg_wdata[15:0];
            3'd5: io_m  = cfg_wdata[15:0];
            default: ;
          endcase
        end
      end
      e_lock = m_lock;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      checks++;
      if (xl_valid !== e_valid || xl_miss !== e_miss || locked !== e_lock ||
          (e_valid && (xl_addr !== e_addr || xl_type !== e_type || xl_win !== e_win))) begin
        errors++;
        $display("FAIL %s model: got v=%0b m=%0b l=%0b a=%h t=%0d w=%0d exp v=%0b m=%0b l=%0b a=%h t=%0d w=%0d",
                 exp_tag, xl_valid, xl_miss, locked, xl_addr, xl_type, xl_win,
                 e_valid, e_miss, e_lock, e_addr, e_type, e_win);
      end
    end
  end

  task automatic cfg(input bit [2:0] s, input bit [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic req(input bit [31:0] a, input string tag);
    @(negedge clk); cur_tag = tag; req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic expect_hit(input string tag, input bit [1:0] w, input bit [31:0] a, input bit [2:0] t);
    checks++;
    if (!(xl_valid === 1 && xl_miss === 0 && xl_win === w && xl_addr === a && xl_type === t)) begin
      errors++;
      $display("FAIL %s: got v=%0b m=%0b w=%0d a=%h t=%0d exp hit w=%0d a=%h t=%0d",
               tag, xl_valid, xl_miss, xl_win, xl_addr, xl_type, w, a, t);
    end
  endtask

  task automatic expect_miss(input string tag);
    checks++;
    if (!(xl_valid === 0 && xl_miss === 1)) begin
      errors++;
      $display("FAIL %s: got v=%0b m=%0b exp v=0 m=1", tag, xl_valid, xl_miss);
    end
  endtask

  task automatic expect_lock(input string tag, input bit l);
    checks++;
    if (locked !== l) begin
      errors++;
      $display("FAIL %s: got locked=%0b exp %0b", tag, locked, l);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; req_valid = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    // R1: reset state
    checks++;
    if (xl_valid !== 0 || xl_miss !== 0 || locked !== 0) begin
      errors++;
      $display("FAIL R1: got v=%0b m=%0b l=%0b exp 0 0 0", xl_valid, xl_miss, locked);
    end
    req(32'h4000_1234, "R1"); expect_miss("R1");
    // R2 R3 R5: 256 MB window 0, low bits forced
    cfg(0, 32'h4000_0081); cfg(1, 32'h0000_0006);
    req(32'h4123_4567, "R3"); expect_hit("R3", 0, 32'h0123_4564, 3'b011);
    cfg(1, 32'h0000_0007);
    req(32'h4123_4567, "R5"); expect_hit("R5", 0, 32'h0123_4567, 3'b011);
    // R4: window 1 memory-multiple
    cfg(2, 32'h5000_0081); cfg(3, 32'h0000_100C);
    req(32'h5ABC_DEF3, "R4"); expect_hit("R4", 1, 32'h1ABC_DEF0, 3'b110);
    // R7: I/O window
    cfg(4, 32'h0000_6001); cfg(5, 32'h0000_0000);
    req(32'h6012_3457, "R7"); expect_hit("R7", 2, 32'h0012_3457, 3'b001);
    // R6: enlarge window 0 to 512 MB, it hides window 1
    cfg(0, 32'h4000_0091);
    req(32'h5ABC_DEF3, "R6"); expect_hit("R6", 0, 32'h1ABC_DEF3, 3'b011);
    // R4: window 1 as 16 MB configuration window
    cfg(2, 32'h6100_0041); cfg(3, 32'h0000_000B);
    req(32'h6100_0A10, "R4"); expect_hit("R4", 1, 32'h0000_0A10, 3'b101);
    // R6: I/O window overlapping window 1 loses
    cfg(4, 32'h0000_6101);
    req(32'h6100_0A12, "R6"); expect_hit("R6", 1, 32'h0000_0A12, 3'b101);
    // R8: size code 12 never matches, disabled window never matches
    cfg(0, 32'h4000_00C1);
    req(32'h4000_0000, "R8"); expect_miss("R8");
    cfg(0, 32'h4000_0080);
    req(32'h4000_0000, "R8"); expect_miss("R8");
    // R9: lock drops writes, key unlocks
    cfg(6, 32'h0000_4000); expect_lock("R9", 1);
    cfg(0, 32'h4000_0081);
    req(32'h4000_0000, "R9"); expect_miss("R9");
    cfg(6, 32'h0000_A05F); expect_lock("R9", 0);
    cfg(0, 32'h4000_0081);
    req(32'h4000_0000, "R9"); expect_hit("R9", 0, 32'h0000_0003 & 32'hFFFF_FFFC, 3'b011);
    // R2: 1 MB window edges, base low bits ignored
    cfg(0, 32'h4000_0001);
    req(32'h400F_FFFF, "R2"); expect_hit("R2", 0, 32'h000F_FFFF, 3'b011);
    req(32'h4010_0000, "R2"); expect_miss("R2");
    cfg(0, 32'h4050_0081);
    req(32'h4000_0000, "R2"); expect_hit("R2", 0, 32'h0000_0000, 3'b011);
    // R3: 2 GB window with map address above the size boundary
    cfg(0, 32'h8000_00B1); cfg(1, 32'h0000_F007);
    req(32'hFFFF_FFFC, "R3"); expect_hit("R3", 0, 32'hFFFF_FFFC, 3'b011);
    // R10: idle cycle stays quiet
    @(negedge clk);
    checks++;
    if (xl_valid !== 0 || xl_miss !== 0) begin
      errors++;
      $display("FAIL R10: got v=%0b m=%0b exp 0 0", xl_valid, xl_miss);
    end
    // R10: write and request on the same edge use the old words
    @(negedge clk); cur_tag = "R10";
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h0; req_valid = 1; req_addr = 32'h8000_0010;
    @(negedge clk); cfg_we = 0; req_valid = 0;
    expect_hit("R10", 0, 32'h8000_0010, 3'b011);
    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cur_tag = "R2";
      req_valid = ($urandom_range(0, 3) != 0);
      req_addr = {8'($urandom_range(8'h3E, 8'h62)), 24'($urandom)};
      cfg_we = ($urandom_range(0, 5) == 0);
      cfg_sel = 3'($urandom_range(0, 6));
      cfg_wdata = $urandom;
      if (cfg_sel == 6 && $urandom_range(0, 1) == 0) cfg_wdata[15:0] = 16'hA05F;
      if (cfg_sel == 0 || cfg_sel == 2) cfg_wdata[31:28] = 4'($urandom_range(3, 6));
      if (cfg_sel == 4) cfg_wdata[15:8] = 8'($urandom_range(8'h3E, 8'h62));
    end
    @(negedge clk); cfg_we = 0; req_valid = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule